// File: doc/BRIEF.md
# Interval-Based Speed and Voltage Governor

The governor picks one of four processor operating points once per fixed scheduling window. It counts the ticks in the window where runnable work was pending and uses that busy fraction to decide whether to move one step faster, one step slower, or stay where it is. The new level applies to the whole next window. Each level drives a supply-voltage code and a clock-divider value for the clock and regulator logic outside the block. A one-cycle strobe marks every window edge where the level changes.

Work is counted in full-speed units. A busy tick at a reduced level completes only part of a full-speed tick of work. The part left over goes into an excess backlog that carries from one window to the next. Idle ticks at a reduced level work the backlog down, and an idle tick at full speed clears it. At each window edge the backlog is compared with the idle time that could have absorbed it, counting only soft idle. Ticks spent waiting on a device count as idle but cannot be reclaimed. If the backlog is larger, the next window runs at full speed whatever the busy fraction was. A floor input limits how slow the governor may go. Its main use is a floor at the 2.2 V point.

Top module: `dvfs_governor`

## Requirements
- R1: While reset is asserted and after it is released, the block sits at level 0 with `vcode`=50, `clk_div`=16 and `change`=0 until the first window edge.
- R2: Levels 0, 1, 2 and 3 run at 100, 66, 44 and 20 percent of full speed. `vcode` gives the supply in tenths of a volt (50, 33, 22, 10). `clk_div` gives the period stretch in unsigned 4.4 fixed point (16, 24, 36, 80).
- R3: A window is INTERVAL = TICKS_PER_MS*WINDOW_MS ticks. Counting starts at the first clock after reset release. The level changes only at the last tick of each window and stays constant in between.
- R4: If the busy ticks of the window, times 10, are fewer than 5*INTERVAL, the next level is one step slower (index +1).
- R5: If the busy ticks, times 10, are more than 7*INTERVAL, the next level is one step faster (index −1, never below 0). In the range between the two thresholds the level holds.
- R6: A tick with `run_req` high adds 100 minus the speed percent to the excess backlog. An idle tick at levels 1 to 3 subtracts the speed percent from the backlog, with a floor of zero. The backlog carries across windows.
- R7: At a window edge, if the backlog exceeds 100 times the soft-idle ticks of that window, the next level is 0, whatever the busy fraction.
- R8: A tick with `hard_wait` high and `run_req` low is idle time that does not count toward the reclaimable amount in R7.
- R9: The level never goes slower than `min_level` as sampled at the window edge. A level already slower than a newly lowered floor moves to the floor at the next edge.
- R10: The backlog saturates at 2^EXCESS_W−1 and does not wrap.
- R11: An idle tick while running at level 0 clears the backlog to zero.
- R12: `change` is high for exactly the one cycle after a window edge at which the level differed from the level before that edge. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| run_req | input | 1 | Runnable work is pending this tick |
| hard_wait | input | 1 | Idle tick caused by a device wait (used when `run_req` is low) |
| min_level | input | 2 | Slowest permitted level index (3 allows all) |
| level | output | 2 | Current operating level, 0 = full speed |
| vcode | output | 6 | Supply request in tenths of a volt |
| clk_div | output | 8 | Clock period stretch, unsigned 4.4 fixed point |
| change | output | 1 | One-cycle strobe after a level change |

## Verification
The checker assumes `run_req` and `hard_wait` are never high in the same tick. It also assumes `min_level` changes only while reset is held or in the cycle after a window edge, so the floor seen at an edge is the one in force for the whole next window. The bench keeps to both rules. It drives each window as a run of busy ticks, then device-wait ticks, then soft idle, and it changes the floor only at window starts. Every scenario starts from a fresh reset, so the backlog carried into the checked window is known exactly.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  typedef logic [1:0] level_t;

  localparam level_t LVL_FULL    = 2'd0;
  localparam level_t LVL_SLOWEST = 2'd3;

  // speed of each level in percent of full speed
  function automatic logic [6:0] speed_pct(input level_t lv);
    case (lv)
      2'd0:    speed_pct = 7'd100;
      2'd1:    speed_pct = 7'd66;
      2'd2:    speed_pct = 7'd44;
      default: speed_pct = 7'd20;
    endcase
  endfunction

  // supply request in tenths of a volt
  function automatic logic [5:0] supply_code(input level_t lv);
    case (lv)
      2'd0:    supply_code = 6'd50;
      2'd1:    supply_code = 6'd33;
      2'd2:    supply_code = 6'd22;
      default: supply_code = 6'd10;
    endcase
  endfunction

  // period stretch, unsigned 4.4 fixed point
  function automatic logic [7:0] period_stretch(input level_t lv);
    case (lv)
      2'd0:    period_stretch = 8'd16;
      2'd1:    period_stretch = 8'd24;
      2'd2:    period_stretch = 8'd36;
      default: period_stretch = 8'd80;
    endcase
  endfunction

endpackage

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int N = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic last_tick
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt_q;

  assign last_tick = (cnt_q == CW'(N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (last_tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/work_ledger.sv
module work_ledger #(
  parameter int N        = 50000,
  parameter int EXCESS_W = 24,
  localparam int TICK_W  = $clog2(N + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_req,
  input  logic                hard_wait,
  input  logic                last_tick,
  input  logic [6:0]          speed,
  input  logic                at_full,
  output logic [TICK_W-1:0]   busy_tot,
  output logic [TICK_W-1:0]   soft_tot,
  output logic [EXCESS_W-1:0] excess_nxt,
  output logic [EXCESS_W-1:0] excess_q
);
  localparam logic [EXCESS_W-1:0] EXC_MAX = '1;

  logic [TICK_W-1:0]   busy_q, soft_q;
  logic                soft_idle;
  logic [EXCESS_W:0]   grown;
  logic [EXCESS_W-1:0] spd_ext;

  assign soft_idle = !run_req && !hard_wait;
  assign busy_tot  = busy_q + TICK_W'(run_req);
  assign soft_tot  = soft_q + TICK_W'(soft_idle);
  assign spd_ext   = EXCESS_W'(speed);
  assign grown     = {1'b0, excess_q} + (EXCESS_W + 1)'(7'd100 - speed);

  always_comb begin
    if (run_req)
      excess_nxt = grown[EXCESS_W] ? EXC_MAX : grown[EXCESS_W-1:0];
    else if (at_full)
      excess_nxt = '0;
    else if (excess_q > spd_ext)
      excess_nxt = excess_q - spd_ext;
    else
      excess_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= '0;
      soft_q   <= '0;
      excess_q <= '0;
    end else begin
      busy_q   <= last_tick ? '0 : busy_tot;
      soft_q   <= last_tick ? '0 : soft_tot;
      excess_q <= excess_nxt;
    end
  end
endmodule

// File: rtl/level_picker.sv
module level_picker
  import dvfs_pkg::*;
#(
  parameter int N        = 50000,
  parameter int EXCESS_W = 24,
  localparam int TICK_W  = $clog2(N + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                last_tick,
  input  logic [TICK_W-1:0]   busy_tot,
  input  logic [TICK_W-1:0]   soft_tot,
  input  logic [EXCESS_W-1:0] excess_nxt,
  input  level_t              min_level,
  output level_t              level_q,
  output logic                change_q
);
  localparam int CMP_W = ((EXCESS_W > TICK_W + 7) ? EXCESS_W : TICK_W + 7) + 2;
  localparam logic [CMP_W-1:0] HI_LIM = CMP_W'(7 * N);
  localparam logic [CMP_W-1:0] LO_LIM = CMP_W'(5 * N);

  logic [CMP_W-1:0] reclaim, busy10, backlog;
  logic             overrun, go_up, go_down;
  level_t           raw, target;

  assign reclaim = CMP_W'(soft_tot) * CMP_W'(100);
  assign busy10  = CMP_W'(busy_tot) * CMP_W'(10);
  assign backlog = CMP_W'(excess_nxt);
  assign overrun = backlog > reclaim;
  assign go_up   = busy10 > HI_LIM;
  assign go_down = busy10 < LO_LIM;

  always_comb begin
    if (overrun)
      raw = LVL_FULL;
    else if (go_up)
      raw = (level_q == LVL_FULL) ? LVL_FULL : level_q - 2'd1;
    else if (go_down)
      raw = (level_q == LVL_SLOWEST) ? LVL_SLOWEST : level_q + 2'd1;
    else
      raw = level_q;
    target = (raw > min_level) ? min_level : raw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q  <= LVL_FULL;
      change_q <= 1'b0;
    end else if (last_tick) begin
      level_q  <= target;
      change_q <= (target != level_q);
    end else begin
      change_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dvfs_governor.sv
module dvfs_governor
  import dvfs_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int WINDOW_MS    = 50,
  parameter int EXCESS_W     = 24,
  localparam int INTERVAL    = TICKS_PER_MS * WINDOW_MS,
  localparam int TICK_W      = $clog2(INTERVAL + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_req,
  input  logic       hard_wait,
  input  logic [1:0] min_level,
  output logic [1:0] level,
  output logic [5:0] vcode,
  output logic [7:0] clk_div,
  output logic       change
);
  logic                last_tick;
  logic [TICK_W-1:0]   busy_tot, soft_tot;
  logic [EXCESS_W-1:0] excess_nxt, excess_q;
  level_t              level_q;

  interval_timer #(.N(INTERVAL)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .last_tick (last_tick)
  );

  work_ledger #(.N(INTERVAL), .EXCESS_W(EXCESS_W)) u_ledger (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_req    (run_req),
    .hard_wait  (hard_wait),
    .last_tick  (last_tick),
    .speed      (speed_pct(level_q)),
    .at_full    (level_q == LVL_FULL),
    .busy_tot   (busy_tot),
    .soft_tot   (soft_tot),
    .excess_nxt (excess_nxt),
    .excess_q   (excess_q)
  );

  level_picker #(.N(INTERVAL), .EXCESS_W(EXCESS_W)) u_picker (
    .clk        (clk),
    .rst_n      (rst_n),
    .last_tick  (last_tick),
    .busy_tot   (busy_tot),
    .soft_tot   (soft_tot),
    .excess_nxt (excess_nxt),
    .min_level  (min_level),
    .level_q    (level_q),
    .change_q   (change)
  );

  assign level   = level_q;
  assign vcode   = supply_code(level_q);
  assign clk_div = period_stretch(level_q);
endmodule

// File: rtl/dvfs_governor_chk.sv
module dvfs_governor_chk #(
  parameter int N        = 50000,
  parameter int EXCESS_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                run_req,
  input logic [1:0]          min_level,
  input logic [1:0]          level,
  input logic [5:0]          vcode,
  input logic [7:0]          clk_div,
  input logic                change,
  input logic [EXCESS_W-1:0] excess
);
  localparam int CW = $clog2(N + 1);
  localparam logic [EXCESS_W-1:0] EXC_MAX = '1;

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)                  phase <= '0;
    else if (phase == CW'(N - 1)) phase <= '0;
    else                         phase <= phase + CW'(1);
  end

  assert_hold_inside_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != '0) |-> $stable(level));

  assert_strobe_on_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == '0) |-> (change == (level != $past(level))));

  assert_strobe_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != '0) |-> !change);

  assert_floor_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == '0) |-> (level <= $past(min_level)));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (excess == EXC_MAX && run_req && level != 2'd0) |=> (excess == EXC_MAX));

  assert_full_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 2'd0 && !run_req) |=> (excess == '0));

  assert_full_point_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 2'd0) |-> (vcode == 6'd50 && clk_div == 8'd16));

  assert_slow_point_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 2'd3) |-> (vcode == 6'd10 && clk_div == 8'd80));
endmodule

bind dvfs_governor dvfs_governor_chk #(.N(INTERVAL), .EXCESS_W(EXCESS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_req   (run_req),
  .min_level (min_level),
  .level     (level),
  .vcode     (vcode),
  .clk_div   (clk_div),
  .change    (change),
  .excess    (excess_q)
);

// File: tb/test_dvfs_governor.sv
module test_dvfs_governor;
  localparam int CLK_PERIOD = 10;
  localparam int TPM = 10;
  localparam int WMS = 2;
  localparam int NW  = TPM * WMS;   // 20 ticks per window

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_req = 1'b0;
  logic       hard_wait = 1'b0;
  logic [1:0] min_level = 2'd3;
  logic [1:0] level;
  logic [5:0] vcode;
  logic [7:0] clk_div;
  logic       change;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dvfs_governor #(.TICKS_PER_MS(TPM), .WINDOW_MS(WMS), .EXCESS_W(10)) i_dvfs_governor (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_req   (run_req),
    .hard_wait (hard_wait),
    .min_level (min_level),
    .level     (level),
    .vcode     (vcode),
    .clk_div   (clk_div),
    .change    (change)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] floor);
    @(negedge clk);
    rst_n = 1'b0; run_req = 1'b0; hard_wait = 1'b0; min_level = floor;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one window: busy ticks, then device-wait ticks, then soft idle
  task automatic window(input int nrun, input int nhard);
    for (int i = 0; i < NW; i++) begin
      run_req   = (i < nrun);
      hard_wait = (i >= nrun) && (i < nrun + nhard);
      @(negedge clk);
    end
    run_req = 1'b0; hard_wait = 1'b0;
  endtask

  task automatic expect_level(input string tag, input int lv, input int strobe);
    chk({tag, " level"}, level, lv);
    chk({tag, " change"}, change, strobe);
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 level in reset", level, 0);
    chk("R1 vcode in reset", vcode, 50);
    chk("R1 clk_div in reset", clk_div, 16);
    chk("R1 change in reset", change, 0);
    do_reset(2'd3);
    @(negedge clk);
    chk("R1 level after release", level, 0);
    chk("R1 change after release", change, 0);
  endtask

  task automatic t_window_edge;
    do_reset(2'd3);
    for (int i = 0; i < NW - 1; i++) @(negedge clk);
    chk("R3 level one tick before edge", level, 0);
    chk("R3 change one tick before edge", change, 0);
    @(negedge clk);
    chk("R3 level at edge", level, 1);
    chk("R3 change at edge", change, 1);
    @(negedge clk);
    chk("R12 strobe single cycle", change, 0);
  endtask

  task automatic t_step_down_table;
    do_reset(2'd3);
    window(0, 0);
    expect_level("R4 idle to 1", 1, 1);
    chk("R2 vcode level1", vcode, 33);
    chk("R2 clk_div level1", clk_div, 24);
    window(0, 0);
    expect_level("R4 idle to 2", 2, 1);
    chk("R2 vcode level2", vcode, 22);
    chk("R2 clk_div level2", clk_div, 36);
    window(0, 0);
    expect_level("R4 idle to 3", 3, 1);
    chk("R2 vcode level3", vcode, 10);
    chk("R2 clk_div level3", clk_div, 80);
    window(0, 0);
    expect_level("R9 R12 hold at slowest", 3, 0);
  endtask

  task automatic t_step_up;
    do_reset(2'd3);
    window(0, 0);
    window(15, 0);  // backlog 180 vs 500 reclaimable, 75 percent busy
    expect_level("R5 step up", 0, 1);
  endtask

  task automatic t_hold_band;
    do_reset(2'd3);
    window(0, 0);
    window(12, 0);  // 60 percent, backlog drains to 0
    expect_level("R5 R6 hold in band", 1, 0);
  endtask

  task automatic t_override_and_clear;
    do_reset(2'd3);
    repeat (3) window(0, 0);
    window(13, 0);  // backlog 883 vs 700 reclaimable
    expect_level("R7 override to full", 0, 1);
    window(9, 11);  // idle at full clears backlog, 45 percent busy
    expect_level("R11 cleared then step down", 1, 1);
  endtask

  task automatic t_hard_wait;
    do_reset(2'd3);
    repeat (3) window(0, 0);
    window(11, 9);  // backlog 700, nothing reclaimable
    expect_level("R8 device wait not reclaimable", 0, 1);
    do_reset(2'd3);
    repeat (3) window(0, 0);
    window(11, 0);  // backlog 700 vs 900 reclaimable, 55 percent
    expect_level("R8 R6 soft idle absorbs", 3, 0);
  endtask

  task automatic t_saturate;
    do_reset(2'd3);
    repeat (3) window(0, 0);
    window(14, 0);  // saturates at 1023, drains to 903 vs 600
    expect_level("R10 saturated backlog forces full", 0, 1);
  endtask

  task automatic t_floor;
    do_reset(2'd2);
    window(0, 0);
    expect_level("R9 floor2 first step", 1, 1);
    window(0, 0);
    expect_level("R9 floor2 second step", 2, 1);
    window(0, 0);
    expect_level("R9 floor2 stays", 2, 0);
    chk("R9 floor2 vcode", vcode, 22);
    do_reset(2'd3);
    repeat (3) window(0, 0);
    min_level = 2'd1;
    window(0, 0);
    expect_level("R9 clamp to raised floor", 1, 1);
    window(0, 0);
    expect_level("R9 hold at floor", 1, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    t_reset_state();
    t_window_edge();
    t_step_down_table();
    t_step_up();
    t_hold_band();
    t_override_and_clear();
    t_hard_wait();
    t_saturate();
    t_floor();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule